// File: doc/BRIEF.md
# Serial Audio Receiver with Word-Length and Sample-Rate Detection

This block takes a stereo serial audio stream in the common three-wire form (bit clock, word select and serial data) and turns it into parallel left/right sample pairs. The three stream wires are treated as asynchronous inputs and sampled by one fast system clock. That clock also serves as the reference for timing the stream. Each channel word is placed MSB-aligned in a 32-bit field. A single-cycle strobe marks each finished stereo pair.

The block also works out the stream format by itself. It counts the bits in every channel word to classify the word length as 16, 24 or 32 bits. It times a fixed number of stereo frames against the system clock to recognise the sample rate: 1x, 2x, 4x or 8x of either 44.1 kHz or 48 kHz. From the rate it drives a family select that picks the matching external master oscillator. A format is only reported valid once two successive measurements agree. The select keeps its last good value whenever the rate is not valid, so the oscillator is never switched on the strength of a glitch.

Top module: `i2s_format_rx`

## Requirements
- R1: While reset is held, and on the first cycles after it is released, the outputs `smp_stb`, `depth_ok`, `rate_ok` and `fam48_sel` are all 0.
- R2: A data bit is sampled at each rising edge of `i2s_bck`. It belongs to the channel that `i2s_ws` showed at the previous rising edge (0 = left, 1 = right). Bits arrive MSB first. Each word is left-justified in 32 bits with zero fill below its LSB, and bits beyond the 32nd are dropped.
- R3: When the right word of a frame ends, `smp_stb` pulses for one cycle with `smp_left`/`smp_right` holding that frame's words. The end of the right word is seen at the first bit of the next left word. A frame whose left word did not begin at a word-select change gives no strobe, so the first frame after reset gives none.
- R4: The bits in each finished word are classified as follows: fewer than 16 gives `depth_code` 3 (unknown), 16 to 23 gives 0, 24 to 31 gives 1, and 32 or more gives 2. `depth_ok` rises after two consecutive words share a known class. It clears on a differing class or on an unknown one.
- R5: The rate is measured as the clock cycles spanned by MEAS_FRAMES frames, each frame running from one left-word start to the next. The count is compared with windows of CLK_HZ*MEAS_FRAMES/fs ± TOL_PCT percent. `rate_code[0]` is the family (0 = 44.1 kHz based, 1 = 48 kHz based) and `rate_code[2:1]` is the multiplier (0 = 1x, 1 = 2x, 2 = 4x, 3 = 8x). The 8x codes are recognised when HIGH_RATES is 1, which is the default.
- R6: `rate_ok` rises when two consecutive measurements give the same code. A measurement with a different code clears it and becomes the new candidate. A measurement outside every window also clears it.
- R7: While `rate_ok` is 1, `fam48_sel` equals `rate_code[0]`. While `rate_ok` is 0, `fam48_sel` holds its last value.
- R8: If no left-word start arrives within the upper bound of the slowest window, `rate_ok` clears, even while the bit clock keeps running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System and reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| i2s_bck | input | 1 | Serial bit clock (asynchronous) |
| i2s_ws | input | 1 | Word select, 0 = left (asynchronous) |
| i2s_sd | input | 1 | Serial data (asynchronous) |
| smp_stb | output | 1 | One-cycle strobe for a new stereo pair |
| smp_left | output | 32 | Left word, MSB aligned |
| smp_right | output | 32 | Right word, MSB aligned |
| depth_code | output | 2 | Word length class |
| depth_ok | output | 1 | Word length confirmed |
| rate_code | output | 3 | Multiplier and family of the sample rate |
| rate_ok | output | 1 | Sample rate confirmed |
| fam48_sel | output | 1 | Oscillator family select, 1 = 48 kHz family |

## Verification
The hardest situation to reach is a rate change in a live stream, where the measurement window in flight straddles the old and new formats. There the select output must hold the old family while validity is down. The stimulus plays one unbroken stream that moves through six formats, crossing both families and both word-length extremes. It records the select value in the cycle validity falls. Word select is then frozen while the bit clock keeps toggling, which drives the window timeout that no well-formed stream can produce.

// File: rtl/i2s_format_rx_pkg.sv
package i2s_format_rx_pkg;

  typedef enum logic [1:0] {
    DEPTH_16  = 2'd0,
    DEPTH_24  = 2'd1,
    DEPTH_32  = 2'd2,
    DEPTH_UNK = 2'd3
  } depth_e;

  localparam int unsigned RATE_CODES = 8;

  // Nominal sample rate for a code: bit 0 family, bits 2:1 power-of-two multiplier.
  function automatic logic [63:0] code_rate_hz(input logic [2:0] code);
    logic [63:0] base;
    base = code[0] ? 64'd48000 : 64'd44100;
    return base << code[2:1];
  endfunction

  // Window bound in reference-clock cycles for a measurement of n frames.
  function automatic logic [63:0] window_bound(input logic [63:0] clk_hz,
                                               input logic [63:0] frames,
                                               input logic [63:0] tol_pct,
                                               input logic [2:0]  code,
                                               input bit          upper);
    logic [63:0] nom;
    nom = (clk_hz * frames) / code_rate_hz(code);
    if (upper) return (nom * (64'd100 + tol_pct)) / 64'd100;
    else       return (nom * (64'd100 - tol_pct)) / 64'd100;
  endfunction

endpackage

// File: rtl/i2s_pin_sync.sv
module i2s_pin_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bck_in,
  input  logic ws_in,
  input  logic sd_in,
  output logic bit_en,
  output logic ws_s,
  output logic sd_s
);
  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [2:0] chain [SYNC_STAGES];
  logic       bck_last;

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= '0;
          else        chain[0] <= {bck_in, ws_in, sd_in};
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bck_last <= 1'b0;
    else        bck_last <= chain[LAST][2];
  end

  assign bit_en = chain[LAST][2] & ~bck_last;
  assign ws_s   = chain[LAST][1];
  assign sd_s   = chain[LAST][0];
endmodule

// File: rtl/i2s_slot_deser.sv
module i2s_slot_deser #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned CNT_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              ws_bit,
  input  logic              sd_bit,
  output logic              word_done,
  output logic [CNT_W-1:0]  word_len,
  output logic              frame_start,
  output logic              smp_stb,
  output logic [WORD_W-1:0] smp_left,
  output logic [WORD_W-1:0] smp_right
);
  localparam int unsigned IW = $clog2(WORD_W);

  logic              ws_prev_q, ws_prev_n;
  logic              cur_ch_q, cur_ch_n;
  logic              open_q, open_n;
  logic              lok_q, lok_n;
  logic [WORD_W-1:0] shreg_q, shreg_n;
  logic [WORD_W-1:0] lhold_q, lhold_n;
  logic [CNT_W-1:0]  bcnt_q, bcnt_n;
  logic              wdone_q, wdone_n;
  logic [CNT_W-1:0]  wlen_q, wlen_n;
  logic              fstart_q, fstart_n;
  logic              stb_q, stb_n;
  logic [WORD_W-1:0] left_q, left_n;
  logic [WORD_W-1:0] right_q, right_n;
  logic [IW-1:0]     pos;

  assign pos = IW'(WORD_W - 1) - IW'(bcnt_q);

  always_comb begin
    ws_prev_n = ws_prev_q;
    cur_ch_n  = cur_ch_q;
    open_n    = open_q;
    lok_n     = lok_q;
    shreg_n   = shreg_q;
    lhold_n   = lhold_q;
    bcnt_n    = bcnt_q;
    wlen_n    = wlen_q;
    left_n    = left_q;
    right_n   = right_q;
    wdone_n   = 1'b0;
    fstart_n  = 1'b0;
    stb_n     = 1'b0;
    if (bit_en) begin
      ws_prev_n = ws_bit;
      if (ws_prev_q != cur_ch_q) begin
        // channel boundary: close the running word, open a new one
        cur_ch_n = ws_prev_q;
        if (open_q) begin
          wdone_n = 1'b1;
          wlen_n  = bcnt_q;
          if (!cur_ch_q) begin
            lhold_n = shreg_q;
            lok_n   = 1'b1;
          end else if (lok_q) begin
            stb_n   = 1'b1;
            left_n  = lhold_q;
            right_n = shreg_q;
          end
        end
        if (cur_ch_q) lok_n = 1'b0;
        if (!ws_prev_q) fstart_n = 1'b1;
        open_n             = 1'b1;
        shreg_n            = '0;
        shreg_n[WORD_W-1]  = sd_bit;
        bcnt_n             = CNT_W'(1);
      end else begin
        if (bcnt_q < CNT_W'(WORD_W)) shreg_n[pos] = sd_bit;
        if (bcnt_q != '1) bcnt_n = bcnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ws_prev_q <= 1'b0;
      cur_ch_q  <= 1'b0;
      open_q    <= 1'b0;
      lok_q     <= 1'b0;
      shreg_q   <= '0;
      lhold_q   <= '0;
      bcnt_q    <= '0;
      wdone_q   <= 1'b0;
      wlen_q    <= '0;
      fstart_q  <= 1'b0;
      stb_q     <= 1'b0;
      left_q    <= '0;
      right_q   <= '0;
    end else begin
      ws_prev_q <= ws_prev_n;
      cur_ch_q  <= cur_ch_n;
      open_q    <= open_n;
      lok_q     <= lok_n;
      shreg_q   <= shreg_n;
      lhold_q   <= lhold_n;
      bcnt_q    <= bcnt_n;
      wdone_q   <= wdone_n;
      wlen_q    <= wlen_n;
      fstart_q  <= fstart_n;
      stb_q     <= stb_n;
      left_q    <= left_n;
      right_q   <= right_n;
    end
  end

  assign word_done   = wdone_q;
  assign word_len    = wlen_q;
  assign frame_start = fstart_q;
  assign smp_stb     = stb_q;
  assign smp_left    = left_q;
  assign smp_right   = right_q;
endmodule

// File: rtl/i2s_depth_track.sv
module i2s_depth_track
  import i2s_format_rx_pkg::*;
#(
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             word_done,
  input  logic [CNT_W-1:0] word_len,
  output depth_e           depth,
  output logic             depth_ok
);
  depth_e cls;
  depth_e cand_q, cand_n;
  logic   cok_q, cok_n;
  logic   ok_q, ok_n;

  always_comb begin
    if      (word_len < CNT_W'(16)) cls = DEPTH_UNK;
    else if (word_len < CNT_W'(24)) cls = DEPTH_16;
    else if (word_len < CNT_W'(32)) cls = DEPTH_24;
    else                            cls = DEPTH_32;
  end

  always_comb begin
    cand_n = cand_q;
    cok_n  = cok_q;
    ok_n   = ok_q;
    if (word_done) begin
      if (cls == DEPTH_UNK) begin
        cand_n = DEPTH_UNK;
        cok_n  = 1'b0;
        ok_n   = 1'b0;
      end else if (cok_q && cls == cand_q) begin
        ok_n = 1'b1;
      end else begin
        cand_n = cls;
        cok_n  = 1'b1;
        ok_n   = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand_q <= DEPTH_UNK;
      cok_q  <= 1'b0;
      ok_q   <= 1'b0;
    end else begin
      cand_q <= cand_n;
      cok_q  <= cok_n;
      ok_q   <= ok_n;
    end
  end

  assign depth    = cand_q;
  assign depth_ok = ok_q;
endmodule

// File: rtl/i2s_rate_meter.sv
module i2s_rate_meter
  import i2s_format_rx_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 98_304_000,
  parameter int unsigned MEAS_FRAMES = 4,
  parameter int unsigned TOL_PCT     = 2,
  parameter bit          HIGH_RATES  = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_start,
  output logic [2:0] rate_code,
  output logic       rate_ok,
  output logic       fam48_sel
);
  localparam logic [63:0] LIMIT64 =
    window_bound(64'(CLK_HZ), 64'(MEAS_FRAMES), 64'(TOL_PCT), 3'd0, 1'b1) + 64'd1;
  localparam int unsigned CW = $clog2(LIMIT64 + 64'd2);
  localparam int unsigned FW = $clog2(MEAS_FRAMES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(LIMIT64);

  logic          run_q, run_n;
  logic [FW-1:0] fcnt_q, fcnt_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [CW-1:0] meas;
  logic          done, fail;
  logic [RATE_CODES-1:0] hit;
  logic [2:0]    hit_code;
  logic [2:0]    cand_q, cand_n;
  logic          cok_q, cok_n;
  logic          ok_q, ok_n;
  logic          sel_q, sel_n;

  assign meas = cnt_q + CW'(1);

  generate
    for (genvar g = 0; g < RATE_CODES; g++) begin : g_win
      localparam logic [CW-1:0] LO =
        CW'(window_bound(64'(CLK_HZ), 64'(MEAS_FRAMES), 64'(TOL_PCT), 3'(g), 1'b0));
      localparam logic [CW-1:0] HI =
        CW'(window_bound(64'(CLK_HZ), 64'(MEAS_FRAMES), 64'(TOL_PCT), 3'(g), 1'b1));
      if (g >= 6 && !HIGH_RATES) begin : g_off
        assign hit[g] = 1'b0;
      end else begin : g_on
        assign hit[g] = (meas >= LO) && (meas <= HI);
      end
    end
  endgenerate

  always_comb begin
    hit_code = 3'd0;
    for (int i = 0; i < RATE_CODES; i++) begin
      if (hit[i]) hit_code = 3'(i);
    end
  end

  // window sequencing
  always_comb begin
    run_n  = run_q;
    fcnt_n = fcnt_q;
    cnt_n  = run_q ? cnt_q + CW'(1) : cnt_q;
    done   = 1'b0;
    fail   = 1'b0;
    if (frame_start) begin
      if (!run_q) begin
        run_n  = 1'b1;
        cnt_n  = '0;
        fcnt_n = '0;
      end else if (fcnt_q == FW'(MEAS_FRAMES - 1)) begin
        done   = 1'b1;
        cnt_n  = '0;
        fcnt_n = '0;
      end else begin
        fcnt_n = fcnt_q + FW'(1);
      end
    end else if (run_q && cnt_q == LIMIT) begin
      fail  = 1'b1;
      run_n = 1'b0;
      cnt_n = '0;
    end
  end

  // agreement and oscillator select
  always_comb begin
    cand_n = cand_q;
    cok_n  = cok_q;
    ok_n   = ok_q;
    if ((done && !(|hit)) || fail) begin
      cok_n = 1'b0;
      ok_n  = 1'b0;
    end else if (done) begin
      if (cok_q && hit_code == cand_q) begin
        ok_n = 1'b1;
      end else begin
        cand_n = hit_code;
        cok_n  = 1'b1;
        ok_n   = 1'b0;
      end
    end
    sel_n = ok_n ? cand_n[0] : sel_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      fcnt_q <= '0;
      cnt_q  <= '0;
      cand_q <= '0;
      cok_q  <= 1'b0;
      ok_q   <= 1'b0;
      sel_q  <= 1'b0;
    end else begin
      run_q  <= run_n;
      fcnt_q <= fcnt_n;
      cnt_q  <= cnt_n;
      cand_q <= cand_n;
      cok_q  <= cok_n;
      ok_q   <= ok_n;
      sel_q  <= sel_n;
    end
  end

  assign rate_code = cand_q;
  assign rate_ok   = ok_q;
  assign fam48_sel = sel_q;
endmodule

// File: rtl/i2s_format_rx.sv
module i2s_format_rx
  import i2s_format_rx_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 98_304_000,
  parameter int unsigned MEAS_FRAMES = 4,
  parameter int unsigned TOL_PCT     = 2,
  parameter bit          HIGH_RATES  = 1'b1,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        i2s_bck,
  input  logic        i2s_ws,
  input  logic        i2s_sd,
  output logic        smp_stb,
  output logic [31:0] smp_left,
  output logic [31:0] smp_right,
  output logic [1:0]  depth_code,
  output logic        depth_ok,
  output logic [2:0]  rate_code,
  output logic        rate_ok,
  output logic        fam48_sel
);
  localparam int unsigned WORD_W = 32;
  localparam int unsigned CNT_W  = $clog2(WORD_W) + 2;

  logic [1:0]       rst_pipe;
  logic             rst_int_n;
  logic             bit_en, ws_s, sd_s;
  logic             word_done, frame_start;
  logic [CNT_W-1:0] word_len;
  depth_e           depth;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  i2s_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .bck_in (i2s_bck),
    .ws_in  (i2s_ws),
    .sd_in  (i2s_sd),
    .bit_en (bit_en),
    .ws_s   (ws_s),
    .sd_s   (sd_s)
  );

  i2s_slot_deser #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_deser (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .bit_en      (bit_en),
    .ws_bit      (ws_s),
    .sd_bit      (sd_s),
    .word_done   (word_done),
    .word_len    (word_len),
    .frame_start (frame_start),
    .smp_stb     (smp_stb),
    .smp_left    (smp_left),
    .smp_right   (smp_right)
  );

  i2s_depth_track #(.CNT_W(CNT_W)) u_depth (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .word_done (word_done),
    .word_len  (word_len),
    .depth     (depth),
    .depth_ok  (depth_ok)
  );

  i2s_rate_meter #(
    .CLK_HZ      (CLK_HZ),
    .MEAS_FRAMES (MEAS_FRAMES),
    .TOL_PCT     (TOL_PCT),
    .HIGH_RATES  (HIGH_RATES)
  ) u_rate (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .frame_start (frame_start),
    .rate_code   (rate_code),
    .rate_ok     (rate_ok),
    .fam48_sel   (fam48_sel)
  );

  assign depth_code = depth;
endmodule

// File: rtl/i2s_format_rx_chk.sv
module i2s_format_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       smp_stb,
  input logic [1:0] depth_code,
  input logic       depth_ok,
  input logic [2:0] rate_code,
  input logic       rate_ok,
  input logic       fam48_sel
);
  // R3: a stereo pair is announced for exactly one cycle
  p_stb_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb |=> !smp_stb);

  // R4: a confirmed word length is never the unknown class
  p_depth_known_r4: assert property (@(posedge clk) disable iff (!rst_n)
    depth_ok |-> depth_code != 2'd3);

  // R4: confirmation never comes with a class change in the same step
  p_depth_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(depth_ok) |-> $stable(depth_code));

  // R6: the rate code can only move while not confirmed
  p_rate_change_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rate_code) |-> !rate_ok);

  // R6: confirmation only for a code that was already the candidate
  p_rate_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rate_ok) |-> $stable(rate_code));

  // R7: select follows the family while confirmed
  p_sel_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rate_ok |-> fam48_sel == rate_code[0]);

  // R7: select moves only when a rate is confirmed
  p_sel_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fam48_sel) |-> rate_ok);
endmodule

bind i2s_format_rx i2s_format_rx_chk u_chk (.*);

// File: tb/test_i2s_format_rx.sv
module test_i2s_format_rx;
  localparam int unsigned CLK_HZ = 98_304_000;
  localparam int unsigned MEAS   = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bck, ws, sd;
  logic        smp_stb;
  logic [31:0] smp_left, smp_right;
  logic [1:0]  depth_code;
  logic        depth_ok;
  logic [2:0]  rate_code;
  logic        rate_ok;
  logic        fam48_sel;

  int          checks = 0;
  int          errors = 0;
  int          stb_cnt = 0;
  int          drop_cnt = 0;
  logic        sel_at_drop = 1'b0;
  logic        ok_last = 1'b0;
  bit          finished = 1'b0;
  logic [63:0] exp_q[$];
  real         t_acc = 0.0;
  longint      issued = 0;
  int          frame_idx = 0;
  bit          primed = 1'b0;

  always #2.5ns clk = ~clk;

  i2s_format_rx #(.CLK_HZ(CLK_HZ), .MEAS_FRAMES(MEAS)) i_i2s_format_rx (
    .clk(clk), .rst_n(rst_n), .i2s_bck(bck), .i2s_ws(ws), .i2s_sd(sd),
    .smp_stb(smp_stb), .smp_left(smp_left), .smp_right(smp_right),
    .depth_code(depth_code), .depth_ok(depth_ok), .rate_code(rate_code),
    .rate_ok(rate_ok), .fam48_sel(fam48_sel)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor (R2, R3)
  always @(negedge clk) begin
    if (rst_n && smp_stb) begin
      stb_cnt++;
      if (exp_q.size() == 0) begin
        check(1'b0, "R3", "unexpected strobe", {smp_left, smp_right}, 64'd0);
      end else begin
        logic [63:0] e;
        e = exp_q.pop_front();
        check({smp_left, smp_right} == e, "R2", "sample pair", {smp_left, smp_right}, e);
      end
    end
  end

  // records the select value in the cycle rate confirmation falls (R6, R7)
  always @(negedge clk) begin
    if (ok_last && !rate_ok) begin
      drop_cnt++;
      sel_at_drop = fam48_sel;
    end
    ok_last = rate_ok;
  end

  task automatic half_wait(input real step);
    int n;
    t_acc = t_acc + step;
    n = int'($rtoi(t_acc) - issued);
    issued = issued + n;
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] pat(input int k, input int ch);
    if (k % 7 == 3) return '1;
    return (32'h9E37_79B9 * 32'(k * 2 + ch + 1)) ^ (ch != 0 ? 32'hFFFF_0000 : 32'h0000_FFFF);
  endfunction

  task automatic send_frame(input int fs, input int bits);
    real         step;
    logic [63:0] m;
    logic [31:0] w [2];
    step = real'(CLK_HZ) / real'(fs) / real'(4 * bits);
    m = (64'd1 << bits) - 64'd1;
    w[0] = pat(frame_idx, 0) & m[31:0];
    w[1] = pat(frame_idx, 1) & m[31:0];
    frame_idx++;
    if (primed) exp_q.push_back({w[0] << (32 - bits), w[1] << (32 - bits)});
    primed = 1'b1;
    for (int ch = 0; ch < 2; ch++) begin
      for (int j = 0; j < bits; j++) begin
        bck = 1'b0;
        ws  = (j == bits - 1) ? ~ch[0] : ch[0];
        sd  = w[ch][bits - 1 - j];
        half_wait(step);
        bck = 1'b1;
        half_wait(step);
      end
    end
  endtask

  task automatic run_stage(input int fs, input int bits, input int nfr,
                           input logic [2:0] exp_code, input logic [1:0] exp_depth,
                           input bit exp_dok, input bit changed, input bit old_sel);
    int d0;
    d0 = drop_cnt;
    for (int k = 0; k < nfr; k++) send_frame(fs, bits);
    check(rate_ok == 1'b1, "R6", "rate confirmed", 64'(rate_ok), 64'd1);
    check(rate_code == exp_code, "R5", "rate code", 64'(rate_code), 64'(exp_code));
    check(fam48_sel == exp_code[0], "R7", "family select", 64'(fam48_sel), 64'(exp_code[0]));
    check(depth_ok == exp_dok, "R4", "depth confirmed", 64'(depth_ok), 64'(exp_dok));
    check(depth_code == exp_depth, "R4", "depth code", 64'(depth_code), 64'(exp_depth));
    if (changed) begin
      check(drop_cnt > d0, "R6", "confirmation cleared on change", 64'(drop_cnt - d0), 64'd1);
      check(sel_at_drop == old_sel, "R7", "select held while unconfirmed",
            64'(sel_at_drop), 64'(old_sel));
    end
  endtask

  initial begin
    rst_n = 1'b0;
    bck = 1'b0; ws = 1'b0; sd = 1'b0;
    repeat (5) @(negedge clk);
    check(smp_stb == 1'b0 && depth_ok == 1'b0 && rate_ok == 1'b0 && fam48_sel == 1'b0,
          "R1", "outputs in reset", {smp_stb, depth_ok, rate_ok, fam48_sel}, 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(smp_stb == 1'b0 && depth_ok == 1'b0 && rate_ok == 1'b0 && fam48_sel == 1'b0,
          "R1", "outputs after release", {smp_stb, depth_ok, rate_ok, fam48_sel}, 64'd0);

    // R3: the first frame gives no strobe, the second is still pending
    send_frame(48000, 24);
    send_frame(48000, 24);
    check(stb_cnt == 0, "R3", "no strobe for opening frame", 64'(stb_cnt), 64'd0);

    // 48 kHz, 24 bit: code {0,1}, depth 1
    run_stage(48000,  24, 10, 3'd1, 2'd1, 1'b1, 1'b0, 1'b0);
    // 44.1 kHz, 16 bit: code {0,0}, depth 0, select held at 1 while unconfirmed
    run_stage(44100,  16, 12, 3'd0, 2'd0, 1'b1, 1'b1, 1'b1);
    // 96 kHz, 32 bit: code {1,1}, depth 2
    run_stage(96000,  32, 12, 3'd3, 2'd2, 1'b1, 1'b1, 1'b0);
    // 384 kHz, 16 bit: code {3,1}
    run_stage(384000, 16, 12, 3'd7, 2'd0, 1'b1, 1'b1, 1'b1);
    // 352.8 kHz, 16 bit: code {3,0}
    run_stage(352800, 16, 12, 3'd6, 2'd0, 1'b1, 1'b1, 1'b1);
    // 96 kHz with 12-bit words: rate still found, depth unknown (R4)
    run_stage(96000,  12, 12, 3'd3, 2'd3, 1'b0, 1'b1, 1'b0);

    // R8: word select frozen, bit clock running
    ws = 1'b0; sd = 1'b0;
    for (int i = 0; i < 375; i++) begin
      bck = 1'b0; repeat (8) @(negedge clk);
      bck = 1'b1; repeat (8) @(negedge clk);
    end
    check(rate_ok == 1'b0, "R8", "rate cleared on stalled frames", 64'(rate_ok), 64'd0);
    check(fam48_sel == 1'b1, "R7", "select held after stall", 64'(fam48_sel), 64'd1);
    check(exp_q.size() == 0, "R3", "every frame strobed", 64'(exp_q.size()), 64'd0);

    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule